// File: doc/BRIEF.md
# Set-Associative Data Cache with Half-Line Dirty Tracking

This block is a data cache controller for a processor load/store path. Each line holds eight 32-bit words and carries one valid flag, a physical tag and two dirty flags, one for each four-word half. A line leaving the cache writes back only the halves that were modified, and the address for that write-back is built from the stored physical tag and the set index, so no translation step is involved. Whether a store is kept in the cache (write-back) or also sent out at once (write-through) is chosen per access by a region attribute that comes with the request.

A read miss asks memory for the whole line through a simple request port; the eight words arrive in ascending order and the load completes as soon as its own word has arrived. A store that misses, or any store while the cache is switched off, goes straight to the write buffer without allocating a line. The way to replace on a miss is chosen outside the block and supplied with each request. Address layout: bits [4:2] pick the word in the line (bit 4 picks the half), the next log2(SETS) bits pick the set, the remaining upper bits form the tag.

Top module: `hwb_dcache`

## Requirements
- R1: A read that hits returns the stored word with a one-cycle `resp_valid` pulse and makes no memory or write-buffer request; at most one way matches a lookup.
- R2: A read miss issues one single-cycle `mem_rd_req` with the line-aligned address (bits [4:0] zero), installs the eight returned words at word offsets 0 to 7 in arrival order into the requested way, and returns the word at the requested offset.
- R3: A store that hits with `req_wb_region`=1 updates the line, produces no write-buffer traffic and marks the half containing the word dirty (bit 4 of the address = 0 lower half, 1 upper half).
- R4: A store that hits with `req_wb_region`=0 updates the line and sends exactly one word to the write buffer at the request address, leaving the dirty flags clear.
- R5: A store that misses does not allocate a line; it sends one word to the write buffer and makes no memory request.
- R6: Evicting a line with dirty halves sends, before the fill request, four words per dirty half only, lower half first, words in ascending order, each addressed from the stored tag and set.
- R7: Evicting a clean line sends nothing to the write buffer before the fill.
- R8: With `cache_en`=0, a read fetches the line and returns its word without installing it, and a store goes only to the write buffer, leaving cached data unchanged.
- R9: The write buffer port holds `wb_valid`, `wb_addr` and `wb_data` steady until `wb_ready` is seen.
- R10: After reset no line is valid and `resp_valid`, `mem_rd_req` and `wb_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cache_en | input | 1 | Cache enable; 0 bypasses lookup and allocation |
| req_valid | input | 1 | Access request, held until `resp_valid` |
| req_write | input | 1 | 1 store, 0 load |
| req_wb_region | input | 1 | Region attribute: 1 write-back, 0 write-through |
| req_addr | input | ADDR_W | Word-aligned byte address |
| req_wdata | input | 32 | Store data |
| req_victim | input | WAY_W | Way to replace on a miss |
| resp_valid | output | 1 | One-cycle completion pulse |
| resp_rdata | output | 32 | Load data, valid with `resp_valid` |
| mem_rd_req | output | 1 | Line fill request pulse |
| mem_rd_addr | output | ADDR_W | Line-aligned fill address |
| mem_rd_valid | input | 1 | Fill word strobe |
| mem_rd_data | input | 32 | Fill word |
| wb_valid | output | 1 | Write buffer entry valid |
| wb_ready | input | 1 | Write buffer accepts entry |
| wb_addr | output | ADDR_W | Write address |
| wb_data | output | 32 | Write data |

## Verification
The assertions assume the requester keeps `req_valid` and every request field steady until the completion pulse and drops it right after, and that the memory side sends exactly eight fill words, one per strobe, only after a fill request. The bench drives one access at a time from a task that waits for completion, returns fill words only in response to an observed request, and toggles `wb_ready` in an irregular pattern so that write-buffer stalls occur during single stores and multi-word evictions alike. Victim ways are chosen by each scenario so that the lines it evicts are known in advance.

// File: rtl/hwb_dcache_pkg.sv
`timescale 1ns/1ps
package hwb_dcache_pkg;
    localparam int WORD_W     = 32;
    localparam int LINE_WORDS = 8;
    localparam int WIDX_W     = $clog2(LINE_WORDS);
    localparam int OFF_W      = WIDX_W + 2;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOOK,
        ST_WBUF,
        ST_EVICT,
        ST_FREQ,
        ST_FILL
    } ctl_state_t;

    typedef struct packed {
        logic       valid;
        logic [1:0] dirty;
    } line_flags_t;

    // First half to flush: lower when its flag is set, otherwise upper.
    function automatic logic first_half(input logic [1:0] d);
        return ~d[0];
    endfunction
endpackage

// File: rtl/hwb_tag_store.sv
`timescale 1ns/1ps
module hwb_tag_store
    import hwb_dcache_pkg::*;
#(
    parameter int WAYS  = 2,
    parameter int SETS  = 4,
    parameter int TAG_W = 25,
    localparam int WAY_W = $clog2(WAYS),
    localparam int SET_W = $clog2(SETS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [SET_W-1:0] look_set,
    input  logic [TAG_W-1:0] look_tag,
    output logic [WAYS-1:0]  hit_vec,
    input  logic [WAY_W-1:0] vic_way,
    output logic [TAG_W-1:0] vic_tag,
    output logic             vic_valid,
    output logic [1:0]       vic_dirty,
    input  logic             install_en,
    input  logic             mark_en,
    input  logic [WAY_W-1:0] mark_way,
    input  logic             mark_half
);
    line_flags_t      flags_q [WAYS][SETS];
    logic [TAG_W-1:0] tag_q   [WAYS][SETS];

    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign hit_vec[w] = flags_q[w][look_set].valid && (tag_q[w][look_set] == look_tag);
    end

    assign vic_tag   = tag_q[vic_way][look_set];
    assign vic_valid = flags_q[vic_way][look_set].valid;
    assign vic_dirty = flags_q[vic_way][look_set].dirty;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int w = 0; w < WAYS; w++)
                for (int s = 0; s < SETS; s++)
                    flags_q[w][s] <= '0;
        end else begin
            if (install_en) begin
                flags_q[vic_way][look_set] <= '{valid: 1'b1, dirty: 2'b00};
                tag_q[vic_way][look_set]   <= look_tag;
            end
            if (mark_en)
                flags_q[mark_way][look_set].dirty[mark_half] <= 1'b1;
        end
    end

    // R1
    hit_onehot_chk: assert property (@(posedge clk) disable iff (rst) $onehot0(hit_vec));
    // R10
    reset_clear_chk: assert property (@(posedge clk) disable iff (rst) $past(rst) |-> (hit_vec == '0));
endmodule

// File: rtl/hwb_data_store.sv
`timescale 1ns/1ps
module hwb_data_store
    import hwb_dcache_pkg::*;
#(
    parameter int WAYS = 2,
    parameter int SETS = 4,
    localparam int WAY_W = $clog2(WAYS),
    localparam int SET_W = $clog2(SETS)
) (
    input  logic              clk,
    input  logic [SET_W-1:0]  set_idx,
    input  logic              wr_en,
    input  logic [WAY_W-1:0]  wr_way,
    input  logic [WIDX_W-1:0] wr_word,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [WAY_W-1:0]  rd_way,
    input  logic [WIDX_W-1:0] rd_word,
    output logic [WORD_W-1:0] rd_data
);
    logic [WORD_W-1:0] words_q [WAYS][SETS][LINE_WORDS];

    always_ff @(posedge clk) begin
        if (wr_en)
            words_q[wr_way][set_idx][wr_word] <= wr_data;
    end

    assign rd_data = words_q[rd_way][set_idx][rd_word];
endmodule

// File: rtl/hwb_dcache.sv
`timescale 1ns/1ps
module hwb_dcache
    import hwb_dcache_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int WAYS   = 2,
    parameter int SETS   = 4,
    localparam int WAY_W = $clog2(WAYS),
    localparam int SET_W = $clog2(SETS),
    localparam int TAG_W = ADDR_W - SET_W - OFF_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cache_en,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic              req_wb_region,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [WORD_W-1:0] req_wdata,
    input  logic [WAY_W-1:0]  req_victim,
    output logic              resp_valid,
    output logic [WORD_W-1:0] resp_rdata,
    output logic              mem_rd_req,
    output logic [ADDR_W-1:0] mem_rd_addr,
    input  logic              mem_rd_valid,
    input  logic [WORD_W-1:0] mem_rd_data,
    output logic              wb_valid,
    input  logic              wb_ready,
    output logic [ADDR_W-1:0] wb_addr,
    output logic [WORD_W-1:0] wb_data
);
    ctl_state_t        state;
    logic              r_write, r_wbreg, r_en, r_install, ev_half;
    logic [ADDR_W-1:0] r_addr;
    logic [WORD_W-1:0] r_wdata;
    logic [WAY_W-1:0]  r_victim, hit_way, rd_way;
    logic [WIDX_W-1:0] cnt, r_word, rd_word;
    logic [SET_W-1:0]  r_set;
    logic [TAG_W-1:0]  r_tag, vic_tag;
    logic [WAYS-1:0]   hit_vec;
    logic              hit_any, vic_valid, data_we, fill_we, mark_en, install_en;
    logic [1:0]        vic_dirty;
    logic [WORD_W-1:0] rd_data;

    assign r_word  = r_addr[2 +: WIDX_W];
    assign r_set   = r_addr[OFF_W +: SET_W];
    assign r_tag   = r_addr[ADDR_W-1 -: TAG_W];
    assign hit_any = |hit_vec;

    always_comb begin
        hit_way = '0;
        for (int w = 0; w < WAYS; w++)
            if (hit_vec[w]) hit_way = WAY_W'(w);
    end

    assign data_we    = (state == ST_LOOK) && r_write && hit_any && r_en;
    assign mark_en    = data_we && r_wbreg;
    assign fill_we    = (state == ST_FILL) && mem_rd_valid && r_install;
    assign install_en = fill_we && (cnt == WIDX_W'(LINE_WORDS - 1));
    assign rd_way     = (state == ST_EVICT) ? r_victim : hit_way;
    assign rd_word    = (state == ST_EVICT) ? {ev_half, cnt[WIDX_W-2:0]} : r_word;

    hwb_tag_store #(.WAYS(WAYS), .SETS(SETS), .TAG_W(TAG_W)) u_tags (
        .clk(clk), .rst(rst), .look_set(r_set), .look_tag(r_tag), .hit_vec(hit_vec),
        .vic_way(r_victim), .vic_tag(vic_tag), .vic_valid(vic_valid), .vic_dirty(vic_dirty),
        .install_en(install_en), .mark_en(mark_en), .mark_way(hit_way),
        .mark_half(r_word[WIDX_W-1])
    );

    hwb_data_store #(.WAYS(WAYS), .SETS(SETS)) u_data (
        .clk(clk), .set_idx(r_set), .wr_en(data_we | fill_we),
        .wr_way(fill_we ? r_victim : hit_way), .wr_word(fill_we ? cnt : r_word),
        .wr_data(fill_we ? mem_rd_data : r_wdata),
        .rd_way(rd_way), .rd_word(rd_word), .rd_data(rd_data)
    );

    assign mem_rd_req  = (state == ST_FREQ);
    assign mem_rd_addr = {r_addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
    assign wb_valid    = (state == ST_WBUF) || (state == ST_EVICT);
    assign wb_addr     = (state == ST_EVICT)
                         ? {vic_tag, r_set, ev_half, cnt[WIDX_W-2:0], 2'b00} : r_addr;
    assign wb_data     = (state == ST_EVICT) ? rd_data : r_wdata;

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            resp_valid <= 1'b0;
            resp_rdata <= '0;
            cnt        <= '0;
            ev_half    <= 1'b0;
            r_write    <= 1'b0;
            r_wbreg    <= 1'b0;
            r_en       <= 1'b0;
            r_install  <= 1'b0;
            r_addr     <= '0;
            r_wdata    <= '0;
            r_victim   <= '0;
        end else begin
            resp_valid <= 1'b0;
            case (state)
                ST_IDLE: if (req_valid) begin
                    r_write  <= req_write;
                    r_wbreg  <= req_wb_region;
                    r_en     <= cache_en;
                    r_addr   <= req_addr;
                    r_wdata  <= req_wdata;
                    r_victim <= req_victim;
                    state    <= ST_LOOK;
                end
                ST_LOOK: begin
                    if (r_write) begin
                        if (hit_any && r_en && r_wbreg) begin
                            resp_valid <= 1'b1;
                            state      <= ST_IDLE;
                        end else begin
                            state <= ST_WBUF;
                        end
                    end else if (hit_any && r_en) begin
                        resp_valid <= 1'b1;
                        resp_rdata <= rd_data;
                        state      <= ST_IDLE;
                    end else begin
                        cnt       <= '0;
                        r_install <= r_en;
                        if (r_en && vic_valid && (|vic_dirty)) begin
                            ev_half <= first_half(vic_dirty);
                            state   <= ST_EVICT;
                        end else begin
                            state <= ST_FREQ;
                        end
                    end
                end
                ST_WBUF: if (wb_ready) begin
                    resp_valid <= 1'b1;
                    state      <= ST_IDLE;
                end
                ST_EVICT: if (wb_ready) begin
                    cnt <= cnt + 1'b1;
                    if (cnt[WIDX_W-2:0] == '1) begin
                        cnt <= '0;
                        if (!ev_half && vic_dirty[1]) ev_half <= 1'b1;
                        else                          state   <= ST_FREQ;
                    end
                end
                ST_FREQ: begin
                    cnt   <= '0;
                    state <= ST_FILL;
                end
                ST_FILL: if (mem_rd_valid) begin
                    cnt <= cnt + 1'b1;
                    if (cnt == r_word) begin
                        resp_valid <= 1'b1;
                        resp_rdata <= mem_rd_data;
                    end
                    if (cnt == WIDX_W'(LINE_WORDS - 1)) state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R9
    wb_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (wb_valid && !wb_ready) |=> (wb_valid && $stable(wb_addr) && $stable(wb_data)));
    // R6
    evict_dirty_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_EVICT) |-> vic_dirty[ev_half]);
    // R2
    fill_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        mem_rd_req |=> !mem_rd_req);
    // R1
    resp_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        resp_valid |=> !resp_valid);
    // R3
    wb_silent_chk: assert property (@(posedge clk) disable iff (rst)
        ((state == ST_LOOK) && r_write && hit_any && r_en && r_wbreg) |=> !wb_valid);
endmodule

// File: tb/sim_hwb_dcache.sv
`timescale 1ns/1ps
module sim_hwb_dcache;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cache_en = 1'b1, req_valid = 1'b0, req_write = 1'b0, req_wb_region = 1'b1;
    logic [31:0] req_addr = '0, req_wdata = '0;
    logic        req_victim = 1'b0;
    logic        resp_valid, mem_rd_req, wb_valid;
    logic [31:0] resp_rdata, mem_rd_addr, wb_addr, wb_data;
    logic        mem_rd_valid = 1'b0, wb_ready = 1'b0;
    logic [31:0] mem_rd_data = '0;

    logic [31:0] mem  [0:1023];
    logic [31:0] refm [0:1023];
    logic [31:0] wlog_a [0:15];
    logic [31:0] wlog_d [0:15];
    logic [31:0] last_fill;
    int n_chk = 0, n_err = 0, fills = 0, wbs = 0, phase = 0;

    always #2.5 clk = ~clk;

    hwb_dcache u0 (
        .clk(clk), .rst(rst), .cache_en(cache_en), .req_valid(req_valid), .req_write(req_write),
        .req_wb_region(req_wb_region), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_victim(req_victim), .resp_valid(resp_valid), .resp_rdata(resp_rdata),
        .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr), .mem_rd_valid(mem_rd_valid),
        .mem_rd_data(mem_rd_data), .wb_valid(wb_valid), .wb_ready(wb_ready),
        .wb_addr(wb_addr), .wb_data(wb_data)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // memory responder: eight ascending words after each fill request
    initial begin
        forever begin
            @(negedge clk);
            if (mem_rd_req) begin
                fills++;
                last_fill = mem_rd_addr;
                @(negedge clk);
                for (int i = 0; i < 8; i++) begin
                    mem_rd_valid = 1'b1;
                    mem_rd_data  = mem[{last_fill[11:5], 3'(i)}];
                    @(negedge clk);
                end
                mem_rd_valid = 1'b0;
            end
        end
    end

    // write buffer responder with irregular stalls
    initial begin
        forever begin
            @(negedge clk);
            phase++;
            wb_ready = (phase % 3) != 0;
            if (wb_valid && wb_ready) begin
                if (wbs < 16) begin
                    wlog_a[wbs] = wb_addr;
                    wlog_d[wbs] = wb_data;
                end
                mem[wb_addr[11:2]] = wb_data;
                wbs++;
            end
        end
    end

    task automatic access(input logic wr, input logic [31:0] a, input logic [31:0] d,
                          input logic wbm, input logic vic, input logic en,
                          output logic [31:0] rd);
        @(negedge clk);
        req_write = wr; req_addr = a; req_wdata = d; req_wb_region = wbm;
        req_victim = vic; cache_en = en; req_valid = 1'b1;
        do @(negedge clk); while (!resp_valid);
        rd = resp_rdata;
        req_valid = 1'b0;
        if (wr && en) refm[a[11:2]] = d;
        repeat (12) @(negedge clk);
    endtask

    task automatic t_reset();
        check("R10 resp_valid", {31'b0, resp_valid}, 32'd0);
        check("R10 mem_rd_req", {31'b0, mem_rd_req}, 32'd0);
        check("R10 wb_valid", {31'b0, wb_valid}, 32'd0);
    endtask

    task automatic t_miss_hit();
        logic [31:0] rd;
        int f0 = fills, w0 = wbs;
        access(1'b0, 32'h10C, 0, 1'b1, 1'b0, 1'b1, rd);
        check("R2 miss data", rd, refm[32'h10C >> 2]);
        check("R2 one fill", fills, f0 + 1);
        check("R2 fill addr", last_fill, 32'h100);
        for (int i = 0; i < 8; i++) begin
            access(1'b0, 32'h100 + 4 * i, 0, 1'b1, 1'b1, 1'b1, rd);
            check("R2 installed word", rd, refm[(32'h100 >> 2) + i]);
        end
        check("R1 hits make no fill", fills, f0 + 1);
        check("R1 hits make no write", wbs, w0);
    endtask

    task automatic t_wb_evict();
        logic [31:0] rd;
        int f0, w0 = wbs;
        access(1'b1, 32'h114, 32'hDEAD0001, 1'b1, 1'b0, 1'b1, rd);
        check("R3 no write traffic", wbs, w0);
        access(1'b0, 32'h114, 0, 1'b1, 1'b0, 1'b1, rd);
        check("R3 hit returns store", rd, 32'hDEAD0001);
        f0 = fills;
        access(1'b0, 32'h200, 0, 1'b1, 1'b0, 1'b1, rd);
        check("R6 upper half only", wbs, w0 + 4);
        for (int i = 0; i < 4; i++) begin
            check("R6 evict addr", wlog_a[w0 + i], 32'h110 + 4 * i);
            check("R9 evict data under stalls", wlog_d[w0 + i], refm[(32'h110 >> 2) + i]);
        end
        check("R6 fill after evict", fills, f0 + 1);
        check("R2 new line data", rd, refm[32'h200 >> 2]);
    endtask

    task automatic t_wt();
        logic [31:0] rd;
        int f0, w0;
        access(1'b0, 32'h304, 0, 1'b0, 1'b1, 1'b1, rd);
        w0 = wbs; f0 = fills;
        access(1'b1, 32'h308, 32'hCAFE0042, 1'b0, 1'b1, 1'b1, rd);
        check("R4 one forwarded word", wbs, w0 + 1);
        check("R4 forwarded addr", wlog_a[w0], 32'h308);
        check("R4 forwarded data", wlog_d[w0], 32'hCAFE0042);
        access(1'b0, 32'h308, 0, 1'b0, 1'b1, 1'b1, rd);
        check("R4 line updated", rd, 32'hCAFE0042);
        check("R4 no fill", fills, f0);
        access(1'b0, 32'h404, 0, 1'b1, 1'b1, 1'b1, rd);
        check("R7 clean victim silent", wbs, w0 + 1);
        check("R7 fill issued", fills, f0 + 1);
    endtask

    task automatic t_both();
        logic [31:0] rd;
        int w0;
        access(1'b0, 32'h420, 0, 1'b1, 1'b0, 1'b1, rd);
        access(1'b1, 32'h43C, 32'h0B0B0007, 1'b1, 1'b0, 1'b1, rd);
        access(1'b1, 32'h420, 32'h0A0A0000, 1'b1, 1'b0, 1'b1, rd);
        w0 = wbs;
        access(1'b0, 32'h520, 0, 1'b1, 1'b0, 1'b1, rd);
        check("R6 both halves", wbs, w0 + 8);
        for (int i = 0; i < 8; i++) begin
            check("R6 order addr", wlog_a[w0 + i], 32'h420 + 4 * i);
            check("R6 order data", wlog_d[w0 + i], refm[(32'h420 >> 2) + i]);
        end
    endtask

    task automatic t_wmiss();
        logic [31:0] rd;
        int f0 = fills, w0 = wbs;
        access(1'b1, 32'h600, 32'h5EED0600, 1'b1, 1'b0, 1'b1, rd);
        check("R5 direct write", wbs, w0 + 1);
        check("R5 direct addr", wlog_a[w0], 32'h600);
        check("R5 no fill", fills, f0);
        access(1'b0, 32'h600, 0, 1'b1, 1'b0, 1'b1, rd);
        check("R5 not allocated", fills, f0 + 1);
        check("R5 data reached memory", rd, 32'h5EED0600);
    endtask

    task automatic t_dis();
        logic [31:0] rd, old;
        int f0 = fills, w0;
        access(1'b0, 32'h708, 0, 1'b1, 1'b1, 1'b0, rd);
        check("R8 bypass read data", rd, refm[32'h708 >> 2]);
        check("R8 bypass fetch", fills, f0 + 1);
        access(1'b0, 32'h708, 0, 1'b1, 1'b1, 1'b1, rd);
        check("R8 not installed", fills, f0 + 2);
        old = refm[32'h604 >> 2];
        w0 = wbs;
        access(1'b1, 32'h604, 32'h77770604, 1'b1, 1'b0, 1'b0, rd);
        check("R8 bypass store sent", wbs, w0 + 1);
        access(1'b0, 32'h604, 0, 1'b1, 1'b0, 1'b1, rd);
        check("R8 cached copy kept", rd, old);
        check("R8 still a hit", fills, f0 + 2);
    endtask

    initial begin
        for (int i = 0; i < 1024; i++) begin
            mem[i]  = 32'hA5000000 ^ (i * 32'h00010003);
            refm[i] = mem[i];
        end
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_miss_hit();
        t_wb_evict();
        t_wt();
        t_both();
        t_wmiss();
        t_dis();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule